// File: doc/BRIEF.md
# Windowed Duty-Cycle Alarm Monitor

The block watches a set of asynchronous thermal-event inputs, one per channel, over a repeating timer window. The window is a power-of-two number of ticks. A single-cycle `tick` strobe advances time. For every tick in which a channel's synchronised input is high, that channel counts one asserted tick. When the window closes, the channel turns its count into an 8-bit share of the window, where 0x00 is none of it and 0xFF is all of it. The channel publishes this share as its on-time result and holds it until the next window closes.

Each channel has its own 8-bit percentage limit. While the window runs, the channel compares its asserted-tick count with the tick equivalent of that limit. As soon as the count goes past the limit, the channel sets a sticky status bit. The `alert` output is raised while any status bit is set and its mask bit is clear. A limit of 0x00 trips on the first asserted tick. A limit of 0xFF never trips.

Software reaches every setting through a small synchronous register port with one write strobe, an address and a combinational read path. Through this port it reads the results, sets the limits, the mask and the window exponent, and clears status bits.

Top module: `win_duty_mon`

## Requirements
- R1: After reset all results, status bits, mask bits and `alert` are 0, every limit reads 0xFF and the window exponent reads 8.
- R2: The window exponent N is read and written at address 6 and is clamped to the range 3..16 on write. A window is 2^N ticks. Any write to address 6 restarts the window and clears every channel's running count.
- R3: When a window closes, a channel's result becomes min(255, floor(count·256 / 2^N)), where count is the number of ticks in the closed window that saw its input high. The result does not change at any other time.
- R4: A channel's status bit is set on the tick at which count·256 exceeds limit·2^N within the current window.
- R5: With a limit of 0x00, the first asserted tick of a window sets the status bit.
- R6: With a limit of 0xFF, the status bit is never set, even for an input held high for the whole window.
- R7: Status bits read at address 4, with bit c for channel c. They stay set until software writes 1 to that bit. A write of 0 has no effect, and a new set in the same cycle wins over the clear.
- R8: `alert` is high exactly when some status bit is set whose mask bit, at address 5 bit c, is 0.
- R9: Each monitored input passes through two flip-flops before it is counted, so a level that first appears in the cycle of a tick is not counted by that tick.
- R10: Channel c's result reads at address c and its limit at address 2+c, with the limit writable.
- R11: Channels are independent: activity, limits and clears on one channel leave the other channel's result and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-base strobe |
| mon_in | input | CH | Asynchronous thermal-event inputs, one per channel |
| we | input | 1 | Register write strobe |
| addr | input | AW | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from `addr` |
| alert | output | 1 | Alert, high while any unmasked status bit is set |

## Verification
The assertions assume that `tick` is a one-cycle pulse, not held high, and that software changes the exponent only through the register port, so the window counter and running counts never see a shorter window without a restart. The bench pulses `tick` for a single cycle with idle cycles in between. It changes `mon_in` only while no tick is pending and waits three cycles for the synchroniser to settle. It also writes the exponent at the start of every scenario, so each scenario begins on a clean window boundary with known counts.

// File: rtl/dm_pkg.sv
package dm_pkg;

  typedef logic [7:0] code_t;

  // Share of a 2^n-tick window, as an 8-bit code saturated at 0xFF.
  function automatic code_t pct_code(input logic [31:0] ticks, input logic [4:0] n);
    logic [39:0] wide;
    if (n >= 5'd8) wide = {8'd0, ticks} >> (n - 5'd8);
    else           wide = {8'd0, ticks} << (5'd8 - n);
    return (wide > 40'd255) ? 8'hFF : wide[7:0];
  endfunction

  // Largest tick count that does not yet exceed the limit in a 2^n window.
  function automatic logic [31:0] tick_threshold(input code_t lim, input logic [4:0] n);
    logic [39:0] wide;
    wide = ({32'd0, lim} << n) >> 8;
    return wide[31:0];
  endfunction

  function automatic logic [4:0] clamp_exp(input code_t v, input int unsigned lo,
                                           input int unsigned hi);
    if (32'(v) < lo) return 5'(lo);
    if (32'(v) > hi) return 5'(hi);
    return v[4:0];
  endfunction

endpackage

// File: rtl/dm_sync2.sv
module dm_sync2 #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/dm_window.sv
module dm_window #(
  parameter int unsigned NMAX = 16,
  localparam int unsigned CW  = NMAX + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic [4:0]    exp_n,
  output logic          win_end,
  output logic [CW-1:0] win_last
);
  logic [CW-1:0] wc;

  assign win_last = CW'((32'd1 << exp_n) - 32'd1);
  assign win_end  = tick && !restart && (wc == win_last);

  always_ff @(posedge clk) begin
    if (!rst_n)       wc <= '0;
    else if (restart) wc <= '0;
    else if (tick)    wc <= win_end ? '0 : wc + 1'b1;
  end

  assert_win_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wc <= win_last);

  assert_win_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(wc));
endmodule

// File: rtl/dm_channel.sv
module dm_channel #(
  parameter int unsigned NMAX = 16,
  localparam int unsigned CW  = NMAX + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          win_end,
  input  logic [CW-1:0] win_last,
  input  logic [4:0]    exp_n,
  input  logic          level,
  input  logic [7:0]    limit,
  input  logic          clr,
  output logic [7:0]    result,
  output logic          status,
  output logic          over_evt
);
  import dm_pkg::*;

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_inc;
  logic [31:0]   thr;
  logic          sample;

  assign sample  = tick && !restart;
  assign cnt_inc = cnt + CW'(level);
  assign thr     = tick_threshold(limit, exp_n);
  assign over_evt = sample && level && (limit != 8'hFF) && (32'(cnt_inc) > thr);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (sample)  cnt <= win_end ? '0 : cnt_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       result <= '0;
    else if (win_end) result <= pct_code(32'(cnt_inc), exp_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        status <= 1'b0;
    else if (over_evt) status <= 1'b1;
    else if (clr)      status <= 1'b0;
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= win_last);

  assert_result_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(result));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr) |=> status);

  assert_zero_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && level && limit == 8'h00) |=> status);

  assert_full_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> $past(limit) != 8'hFF);
endmodule

// File: rtl/dm_regs.sv
module dm_regs #(
  parameter int unsigned CH   = 2,
  parameter int unsigned AW   = 3,
  parameter int unsigned NMIN = 3,
  parameter int unsigned NMAX = 16,
  parameter int unsigned NRST = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [7:0]           wdata,
  input  logic [CH-1:0][7:0]   results,
  input  logic [CH-1:0]        status,
  output logic [7:0]           rdata,
  output logic [CH-1:0][7:0]   limits,
  output logic [CH-1:0]        mask,
  output logic [4:0]           exp_n,
  output logic                 restart,
  output logic [CH-1:0]        clr
);
  import dm_pkg::*;

  localparam int unsigned A_LIM  = CH;
  localparam int unsigned A_STAT = 2 * CH;
  localparam int unsigned A_MASK = 2 * CH + 1;
  localparam int unsigned A_EXP  = 2 * CH + 2;

  logic wr_stat;
  logic wr_mask;

  assign wr_stat = we && (addr == AW'(A_STAT));
  assign wr_mask = we && (addr == AW'(A_MASK));
  assign restart = we && (addr == AW'(A_EXP));

  for (genvar c = 0; c < CH; c++) begin : g_lim
    always_ff @(posedge clk) begin
      if (!rst_n)                             limits[c] <= 8'hFF;
      else if (we && addr == AW'(A_LIM + c))  limits[c] <= wdata;
    end
    assign clr[c] = wr_stat && wdata[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '0;
    else if (wr_mask) mask <= wdata[CH-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       exp_n <= 5'(NRST);
    else if (restart) exp_n <= clamp_exp(wdata, NMIN, NMAX);
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < CH; c++) begin
      if (addr == AW'(c))         rdata = results[c];
      if (addr == AW'(A_LIM + c)) rdata = limits[c];
    end
    if (addr == AW'(A_STAT)) rdata = 8'(status);
    if (addr == AW'(A_MASK)) rdata = 8'(mask);
    if (addr == AW'(A_EXP))  rdata = 8'(exp_n);
  end

  assert_exp_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(exp_n) >= NMIN) && (32'(exp_n) <= NMAX));
endmodule

// File: rtl/win_duty_mon.sv
module win_duty_mon #(
  parameter int unsigned CH   = 2,
  parameter int unsigned AW   = 3,
  parameter int unsigned NMIN = 3,
  parameter int unsigned NMAX = 16,
  parameter int unsigned NRST = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CH-1:0] mon_in,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          alert
);
  localparam int unsigned CW = NMAX + 1;

  logic [CH-1:0]       level;
  logic [CH-1:0][7:0]  results;
  logic [CH-1:0][7:0]  limits;
  logic [CH-1:0]       status;
  logic [CH-1:0]       mask;
  logic [CH-1:0]       clr;
  logic [CH-1:0]       over_evt;
  logic [4:0]          exp_n;
  logic                restart;
  logic                win_end;
  logic [CW-1:0]       win_last;

  dm_sync2 #(.W(CH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(mon_in), .q(level)
  );

  dm_regs #(.CH(CH), .AW(AW), .NMIN(NMIN), .NMAX(NMAX), .NRST(NRST)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .results(results), .status(status), .rdata(rdata), .limits(limits),
    .mask(mask), .exp_n(exp_n), .restart(restart), .clr(clr)
  );

  dm_window #(.NMAX(NMAX)) u_win (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart), .exp_n(exp_n),
    .win_end(win_end), .win_last(win_last)
  );

  for (genvar c = 0; c < CH; c++) begin : g_ch
    dm_channel #(.NMAX(NMAX)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
      .win_end(win_end), .win_last(win_last), .exp_n(exp_n),
      .level(level[c]), .limit(limits[c]), .clr(clr[c]),
      .result(results[c]), .status(status[c]), .over_evt(over_evt[c])
    );
  end

  assign alert = |(status & ~mask);

  assert_alert_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert) |-> ($past(over_evt) != '0) || ($past(mask) != mask));
endmodule

// File: tb/win_duty_mon_bench.sv
module win_duty_mon_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] mon_in = 2'b00;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       alert;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  win_duty_mon u_win_duty_mon (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mon_in(mon_in), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .alert(alert)
  );

  function automatic int model_code(input int cnt, input int n);
    int v;
    v = (cnt * 256) / (1 << n);
    return (v > 255) ? 255 : v;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    addr = 3'(a);
    #1 v = int'(rdata);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic set_in(input logic [1:0] v);
    @(negedge clk) mon_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input int n);
    set_in(2'b00);
    wr(6, n);
    wr(4, 3);
  endtask

  task automatic t_reset;
    int v;
    for (int c = 0; c < 2; c++) begin
      rd(c, v);     check("R1 result", v, 0);
      rd(2 + c, v); check("R1 limit", v, 8'hFF);
    end
    rd(4, v); check("R1 status", v, 0);
    rd(5, v); check("R1 mask", v, 0);
    rd(6, v); check("R1 exp", v, 8);
    check("R1 alert", int'(alert), 0);
  endtask

  task automatic t_result;
    int v;
    setup(3);
    set_in(2'b01);
    ticks(3);
    rd(0, v); check("R3 hold mid-window", v, 0);
    set_in(2'b00);
    ticks(5);
    rd(0, v); check("R3 ch0 3/8", v, model_code(3, 3));
    rd(1, v); check("R11 ch1 idle", v, 0);
    set_in(2'b10);
    ticks(8);
    rd(1, v); check("R3 ch1 full saturate", v, model_code(8, 3));
    rd(0, v); check("R11 ch0 after idle window", v, 0);
    setup(9);
    set_in(2'b01);
    ticks(100);
    set_in(2'b00);
    ticks(412);
    rd(0, v); check("R3 N=9 100 ticks", v, model_code(100, 9));
  endtask

  task automatic t_sync;
    int v;
    setup(3);
    @(negedge clk); mon_in = 2'b01; tick = 1'b1;
    @(negedge clk); mon_in = 2'b00; tick = 1'b0;
    repeat (3) @(negedge clk);
    ticks(7);
    rd(0, v); check("R9 unsynchronised level not counted", v, 0);
  endtask

  task automatic t_thresh;
    int v;
    wr(2, 8'h40);
    wr(3, 8'hFF);
    setup(3);
    set_in(2'b01);
    ticks(2);
    rd(4, v); check("R4 at threshold", v, 0);
    check("R4 alert quiet", int'(alert), 0);
    ticks(1);
    rd(4, v); check("R4 past threshold", v, ((3 * 256) > (64 * 8)) ? 1 : 0);
    check("R8 alert raised", int'(alert), 1);
    set_in(2'b00);
    ticks(5);
  endtask

  task automatic t_zero;
    int v;
    wr(3, 8'h00);
    setup(3);
    set_in(2'b10);
    ticks(1);
    rd(4, v); check("R5 first tick trips ch1", v, 2);
    set_in(2'b00);
    ticks(7);
  endtask

  task automatic t_full;
    int v;
    wr(2, 8'hFF);
    wr(3, 8'hFF);
    setup(3);
    set_in(2'b11);
    ticks(8);
    rd(4, v); check("R6 never trips", v, 0);
    rd(0, v); check("R6 result all-high", v, 8'hFF);
    check("R6 alert quiet", int'(alert), 0);
    set_in(2'b00);
  endtask

  task automatic t_clear_mask;
    int v;
    wr(2, 0);
    wr(3, 0);
    setup(3);
    set_in(2'b11);
    ticks(1);
    set_in(2'b00);
    rd(4, v); check("R7 both set", v, 3);
    wr(4, 0);
    rd(4, v); check("R7 write zero no effect", v, 3);
    wr(4, 1);
    rd(4, v); check("R11 clear ch0 only", v, 2);
    wr(5, 2);
    check("R8 masked alert", int'(alert), 0);
    wr(5, 0);
    check("R8 unmasked alert", int'(alert), 1);
    ticks(8);
    rd(4, v); check("R7 sticky across window", v, 2);
    wr(4, 2);
    check("R8 alert cleared", int'(alert), 0);
  endtask

  task automatic t_exp;
    int v;
    int prev;
    wr(6, 1);   rd(6, v); check("R2 clamp low", v, 3);
    wr(6, 200); rd(6, v); check("R2 clamp high", v, 16);
    wr(2, 8'hFF);
    setup(3);
    set_in(2'b01);
    rd(0, prev);
    ticks(7);
    rd(0, v); check("R2 window not yet closed", v, prev);
    ticks(1);
    rd(0, v); check("R2 window of 8 ticks", v, model_code(8, 3));
    setup(4);
    set_in(2'b01);
    ticks(10);
    set_in(2'b00);
    wr(6, 4);
    set_in(2'b01);
    ticks(6);
    set_in(2'b00);
    ticks(10);
    rd(0, v); check("R2 restart clears count", v, model_code(6, 4));
    wr(2, 8'h55);
    rd(2, v); check("R10 limit write", v, 8'h55);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_result();
    t_sync();
    t_thresh();
    t_zero();
    t_full();
    t_clear_mask();
    t_exp();
    finish_run();
  end
endmodule